// File: doc/BRIEF.md
# Programmable PLL Divider Chain

This block is the digital half of a clock synthesizer. It runs on the oscillator clock. A feedback divider makes one compare pulse per feedback period for an outside phase detector. The feedback ratio is a power-of-two prescale picked by a one-bit field, times a six-bit modulo count. A second divider derives the system clock from the oscillator by a power of two, chosen by two further bits.

The block also watches the reference input. It passes the reference through a synchronizer and checks the spacing of its edges against the feedback pulse, and from this it declares lock. If the reference goes silent, the block either raises a reset request or moves the system clock onto a fixed fallback divide. A control bit picks which of the two happens.

Software reaches the configuration through one write port and one read port on the oscillator clock. An input tells the block that an external clock is in use. In that case the reference watch is parked and the lock status reads as set.

Top module: `pll_div_chain`

## Requirements
- R1: After reset the configuration reads Y=63, W=0, X=0, Z=0, reset-enable=0. The read word is bit 10 lock, bit 9 reset-enable, bit 8 Z, bit 7 X, bit 6 W, bits 5:0 Y. Lock, limp, reset request, feedback pulse and system clock are all low.
- R2: `fb_pulse_o` is high for exactly one cycle in every 2^(4+2W)·(Y+1) oscillator cycles. A write that changes W or Y restarts the feedback divider.
- R3: The system clock period is 2^(5−X−3Z) oscillator cycles, so 32, 16, 4 or 2, with equal high and low phases.
- R4: A new X or Z setting takes effect only when the output divider completes a full period. Every high or low phase across the change has the width of either the old setting or the new one.
- R5: Lock sets after 16 consecutive reference edges, seen after a two-stage synchronizer, that each fall within one cycle of a feedback terminal count. It does not set after 15.
- R6: Lock clears on a reference edge that misses the window. It also clears on a write that changes W or Y, and on reference loss.
- R7: With reset-enable at 1, `reset_req_o` rises when no synchronized reference edge has arrived for 2·2^(4+2W)·(Y+1) cycles. It stays low before that point and clears after the next reference edge.
- R8: With reset-enable at 0, reference loss sets `limp_o`. The system clock then runs at a free divide-by-32. Limp stays set through misaligned reference edges and clears only when lock is regained, on external-clock mode, or on reset.
- R9: While `ext_clk_i` is high, the lock bit and `lock_o` read 1, and neither limp nor reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference input, asynchronous |
| ext_clk_i | input | 1 | External clock in use, synthesizer bypassed |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 10 | Write data: {rst_en, Z, X, W, Y[5:0]} |
| rd_data_o | output | 11 | Read data: {lock, rst_en, Z, X, W, Y[5:0]} |
| fb_pulse_o | output | 1 | Feedback compare pulse, one cycle wide |
| sys_clk_o | output | 1 | Divided system clock |
| lock_o | output | 1 | Lock status, same as read bit 10 |
| limp_o | output | 1 | System clock on fallback divide |
| reset_req_o | output | 1 | Reset request on reference loss |

## Verification
The bench aims reference edges exactly on the feedback terminal count. It then shifts them by a few cycles to land just outside the one-cycle window. This catches an off-by-one in the hit count, since a design that locks after 15 edges is reported. It also catches a window that is too wide or placed wrong, since a design that keeps lock after a late edge is reported.

The bench samples the reset request a few cycles before and after the loss deadline, so a window of the wrong length shows up. It records each phase width while X and Z change, so a divider that reloads at once and leaves a runt phase is caught. It also drives misaligned edges while in limp, so a design that leaves limp on any edge is caught.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int unsigned Y_W         = 6;
  localparam int unsigned PSC_BASE    = 4;
  localparam int unsigned PSC_W       = PSC_BASE + 2;
  localparam int unsigned WIN_W       = Y_W + PSC_W + 2;
  localparam int unsigned OUT_LOG     = 5;
  localparam int unsigned LIMP_LOG    = 5;
  localparam int unsigned LOCK_HITS   = 16;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned CFG_W       = Y_W + 4;
  localparam int unsigned RD_W        = CFG_W + 1;

  typedef struct packed {
    logic           rst_en;
    logic           z;
    logic           x;
    logic           w;
    logic [Y_W-1:0] y;
  } cfg_t;

  localparam cfg_t CFG_RST = '{rst_en: 1'b0, z: 1'b0, x: 1'b0, w: 1'b0, y: {Y_W{1'b1}}};

  // loss window = 2 x feedback ratio
  function automatic logic [WIN_W-1:0] loss_window(cfg_t c);
    logic [WIN_W-1:0] m;
    m = WIN_W'(c.y) + WIN_W'(1);
    return c.w ? (m << (PSC_BASE + 3)) : (m << (PSC_BASE + 1));
  endfunction
endpackage

// File: rtl/pll_fb_div.sv
module pll_fb_div
  import pll_div_pkg::*;
#(
  parameter int unsigned YW = Y_W,
  parameter int unsigned PB = PSC_BASE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          w_i,
  input  logic [YW-1:0] y_i,
  input  logic          restart_i,
  input  logic [YW-1:0] y_load_i,
  output logic          fb_tick_o,
  output logic          fb_pulse_o
);
  localparam int unsigned PW = PB + 2;
  localparam logic [PW-1:0] PSC_MAX_LO = PW'((1 << PB) - 1);
  localparam logic [PW-1:0] PSC_MAX_HI = PW'((1 << (PB + 2)) - 1);

  logic [PW-1:0] psc_q;
  logic [YW-1:0] ycnt_q;
  logic          psc_tc;

  assign psc_tc    = psc_q == (w_i ? PSC_MAX_HI : PSC_MAX_LO);
  assign fb_tick_o = psc_tc && (ycnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q      <= '0;
      ycnt_q     <= '1;
      fb_pulse_o <= 1'b0;
    end else if (restart_i) begin
      psc_q      <= '0;
      ycnt_q     <= y_load_i;
      fb_pulse_o <= 1'b0;
    end else begin
      fb_pulse_o <= fb_tick_o;
      if (psc_tc) begin
        psc_q  <= '0;
        ycnt_q <= (ycnt_q == '0) ? y_i : ycnt_q - 1'b1;
      end else begin
        psc_q <= psc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_out_div.sv
module pll_out_div
  import pll_div_pkg::*;
#(
  parameter int unsigned OL = OUT_LOG,
  parameter int unsigned LL = LIMP_LOG
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  input  logic z_i,
  input  logic limp_i,
  output logic sys_clk_o
);
  localparam int unsigned CW = OL - 1;

  function automatic logic [CW-1:0] half_m1(logic [1:0] zx);
    int unsigned lg;
    lg = OL - int'(zx[0]) - 3 * int'(zx[1]);
    return CW'((1 << (lg - 1)) - 1);
  endfunction

  logic [1:0]    sel_act_q;
  logic [CW-1:0] cnt_q;
  logic          ph_q;
  logic [LL-1:0] limp_cnt_q;
  logic          wrap;

  assign wrap = cnt_q == half_m1(sel_act_q);

  // select latched only at end of a full period: no runt phases
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_act_q <= 2'b00;
      cnt_q     <= '0;
      ph_q      <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
      if (ph_q) sel_act_q <= {z_i, x_i};
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limp_cnt_q <= '0;
      sys_clk_o  <= 1'b0;
    end else begin
      limp_cnt_q <= limp_cnt_q + 1'b1;
      sys_clk_o  <= limp_i ? limp_cnt_q[LL-1] : ph_q;
    end
  end
endmodule

// File: rtl/pll_ref_mon.sv
module pll_ref_mon
  import pll_div_pkg::*;
#(
  parameter int unsigned SS = SYNC_STAGES,
  parameter int unsigned WW = WIN_W,
  parameter int unsigned LH = LOCK_HITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_i,
  input  logic          ext_i,
  input  logic          fb_tick_i,
  input  logic          clr_lock_i,
  input  logic          rst_en_i,
  input  logic [WW-1:0] window_i,
  output logic          lock_o,
  output logic          limp_o,
  output logic          expired_o
);
  localparam int unsigned HW = $clog2(LH);
  localparam logic [HW-1:0] HITS_M1 = HW'(LH - 1);

  logic [SS-1:0] sync_q;
  logic          ref_prev_q;
  logic          rise;
  logic [WW-1:0] win_q;
  logic          tick_d_q;
  logic          pend_q;
  logic [HW-1:0] good_q;
  logic          hit, miss, clr, lock_set;

  genvar gi;
  generate
    for (gi = 0; gi < SS; gi++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[gi] <= 1'b0;
        else         sync_q[gi] <= (gi == 0) ? ref_i : sync_q[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  assign rise      = sync_q[SS-1] & ~ref_prev_q;
  assign expired_o = win_q >= window_i;

  // window of +-1 cycle around the terminal count
  assign hit      = (rise && (fb_tick_i || tick_d_q)) || (pend_q && fb_tick_i);
  assign miss     = pend_q && !fb_tick_i;
  assign clr      = clr_lock_i || miss || expired_o;
  assign lock_set = !clr && hit && !lock_o && (good_q == HITS_M1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_prev_q <= 1'b0;
      win_q      <= '0;
      tick_d_q   <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      ref_prev_q <= sync_q[SS-1];
      tick_d_q   <= fb_tick_i;
      pend_q     <= rise && !fb_tick_i && !tick_d_q;
      if (ext_i || rise)   win_q <= '0;
      else if (!expired_o) win_q <= win_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      lock_o <= 1'b0;
    end else if (clr) begin
      good_q <= '0;
      lock_o <= 1'b0;
    end else if (hit) begin
      if (good_q != HITS_M1) good_q <= good_q + 1'b1;
      if (lock_set)          lock_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    limp_o <= 1'b0;
    else if (ext_i || lock_set)     limp_o <= 1'b0;
    else if (expired_o && !rst_en_i) limp_o <= 1'b1;
  end
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain
  import pll_div_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_i,
  input  logic            ext_clk_i,
  input  logic            wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [RD_W-1:0] rd_data_o,
  output logic            fb_pulse_o,
  output logic            sys_clk_o,
  output logic            lock_o,
  output logic            limp_o,
  output logic            reset_req_o
);
  cfg_t cfg_q, cfg_d;
  logic wy_chg;
  logic fb_tick;
  logic lock_q;
  logic expired;

  assign cfg_d  = wr_en_i ? cfg_t'(wr_data_i) : cfg_q;
  assign wy_chg = wr_en_i && ({cfg_d.w, cfg_d.y} != {cfg_q.w, cfg_q.y});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg_d;
  end

  pll_fb_div u_fb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .w_i        (cfg_q.w),
    .y_i        (cfg_q.y),
    .restart_i  (wy_chg),
    .y_load_i   (cfg_d.y),
    .fb_tick_o  (fb_tick),
    .fb_pulse_o (fb_pulse_o)
  );

  pll_ref_mon u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_i      (ref_i),
    .ext_i      (ext_clk_i),
    .fb_tick_i  (fb_tick),
    .clr_lock_i (wy_chg),
    .rst_en_i   (cfg_q.rst_en),
    .window_i   (loss_window(cfg_q)),
    .lock_o     (lock_q),
    .limp_o     (limp_o),
    .expired_o  (expired)
  );

  pll_out_div u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .x_i       (cfg_q.x),
    .z_i       (cfg_q.z),
    .limp_i    (limp_o),
    .sys_clk_o (sys_clk_o)
  );

  assign lock_o      = lock_q | ext_clk_i;
  assign reset_req_o = expired & cfg_q.rst_en;
  assign rd_data_o   = {lock_o, cfg_q};
endmodule

// File: rtl/pll_div_chain_chk.sv
module pll_div_chain_chk
  import pll_div_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_clk_i,
  input logic             wr_en_i,
  input logic [CFG_W-1:0] wr_data_i,
  input cfg_t             cfg_q,
  input logic             lock_q,
  input logic             lock_o,
  input logic             limp_o,
  input logic             reset_req_o,
  input logic             fb_pulse_o,
  input logic             sys_clk_o
);
  p_fb_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o);

  p_wr_clears_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_data_i[Y_W:0] != {cfg_q.w, cfg_q.y})) |=> !lock_q);

  p_limp_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(limp_o) |-> (lock_o || $past(ext_clk_i)));

  p_limp_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limp_o && $past(limp_o) && $past(limp_o, 2) && $rose(sys_clk_o)) |=> sys_clk_o);

  p_ext_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_clk_i && $past(ext_clk_i)) |-> (!limp_o && !reset_req_o));
endmodule

bind pll_div_chain pll_div_chain_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ext_clk_i   (ext_clk_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .cfg_q       (cfg_q),
  .lock_q      (lock_q),
  .lock_o      (lock_o),
  .limp_o      (limp_o),
  .reset_req_o (reset_req_o),
  .fb_pulse_o  (fb_pulse_o),
  .sys_clk_o   (sys_clk_o)
);

// File: tb/pll_div_chain_tb_top.sv
module pll_div_chain_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_r = 1'b0;
  logic        ext_r = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_data = '0;
  logic [10:0] rd_data;
  logic        fb_pulse, sys_clk, lock, limp, rst_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int w_s = 0, x_s = 0, z_s = 0, y_s = 63, re_s = 0;
  int pp;

  always #4 clk = ~clk;

  pll_div_chain dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ref_i       (ref_r),
    .ext_clk_i   (ext_r),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .fb_pulse_o  (fb_pulse),
    .sys_clk_o   (sys_clk),
    .lock_o      (lock),
    .limp_o      (limp),
    .reset_req_o (rst_req)
  );

  function automatic int fb_ratio(int w, int y);
    return (y + 1) << (4 + 2 * w);
  endfunction

  function automatic int sys_div(int x, int z);
    return 1 << (5 - x - 3 * z);
  endfunction

  function automatic logic [9:0] pack_cfg();
    return {re_s[0], z_s[0], x_s[0], w_s[0], y_s[5:0]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg();
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = pack_cfg();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fb();
    do @(negedge clk); while (!fb_pulse);
  endtask

  task automatic fb_period(output int p);
    wait_fb();
    p = 0;
    do begin @(negedge clk); p++; end while (!fb_pulse);
  endtask

  task automatic phase_w(output int wd);
    logic lv;
    lv = sys_clk;
    wd = 0;
    while (sys_clk == lv) begin @(negedge clk); wd++; end
  endtask

  task automatic sys_meas(output int hi, output int lo);
    int d;
    phase_w(d);
    phase_w(d);
    if (sys_clk) begin phase_w(hi); phase_w(lo); end
    else begin phase_w(lo); phase_w(hi); end
  endtask

  task automatic ref_sync(int p, int adj);
    wait_fb();
    ext_r = 1'b0;
    repeat (p - 3 + adj) @(negedge clk);
  endtask

  task automatic ref_run(int p, int n);
    for (int i = 0; i < n; i++) begin
      ref_r = 1'b1;
      @(negedge clk);
      ref_r = 1'b0;
      repeat (p - 1) @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int p, hi, lo, seed, old_h, new_h, wd;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 11'h03F, "R1 reset cfg", int'(rd_data), 'h3F);
    chk({lock, limp, rst_req, fb_pulse, sys_clk} == 5'b0, "R1 reset outputs",
        int'({lock, limp, rst_req, fb_pulse, sys_clk}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ext_r = 1'b1;
    @(negedge clk);
    chk(rd_data[10] && lock, "R9 ext lock", int'({rd_data[10], lock}), 3);

    // R2 feedback ratio: directed corners then random
    for (int t = 0; t < 8; t++) begin
      if (t == 0)      begin w_s = 0; y_s = 0;  end
      else if (t == 1) begin w_s = 1; y_s = 63; end
      else begin w_s = $urandom % 2; y_s = $urandom % 64; end
      wr_cfg();
      fb_period(p);
      chk(p == fb_ratio(w_s, y_s), "R2 fb period", p, fb_ratio(w_s, y_s));
    end

    // R3 output divide for all X/Z
    for (int k = 0; k < 4; k++) begin
      x_s = k % 2; z_s = k / 2;
      wr_cfg();
      sys_meas(hi, lo);
      chk(hi + lo == sys_div(x_s, z_s), "R3 sys period", hi + lo, sys_div(x_s, z_s));
      chk(hi == lo, "R3 duty", hi, lo);
    end

    // R4 no runt phases across X/Z change, both directions
    for (int k = 0; k < 2; k++) begin
      old_h = sys_div(x_s, z_s) / 2;
      if (k == 0) begin x_s = 0; z_s = 0; end
      else begin x_s = 1; z_s = 1; end
      new_h = sys_div(x_s, z_s) / 2;
      wr_cfg();
      phase_w(wd);
      for (int i = 0; i < 8; i++) begin
        phase_w(wd);
        chk(wd == old_h || wd == new_h, "R4 phase width", wd, new_h);
      end
      chk(wd == new_h, "R4 new setting", wd, new_h);
    end

    chk(!limp && !rst_req, "R9 ext no loss", int'({limp, rst_req}), 0);

    // R5 lock after 16 aligned edges
    w_s = 0; y_s = 3; x_s = 1; z_s = 0;
    wr_cfg();
    pp = fb_ratio(w_s, y_s);
    ref_sync(pp, 0);
    ref_run(pp, 15);
    chk(!lock, "R5 not after 15", int'(lock), 0);
    ref_run(pp, 1);
    chk(lock && rd_data[10], "R5 lock after 16", int'({lock, rd_data[10]}), 3);
    // R6 miss clears
    repeat (4) @(negedge clk);
    ref_run(pp, 1);
    chk(!lock, "R6 miss clears", int'(lock), 0);
    repeat (pp - 4) @(negedge clk);
    ref_run(pp, 16);
    chk(lock, "R5 relock", int'(lock), 1);
    y_s = 1;
    wr_cfg();
    chk(!lock, "R6 Y write clears", int'(lock), 0);
    pp = fb_ratio(w_s, y_s);

    // R8 limp on loss
    repeat (200) @(negedge clk);
    chk(limp && !rst_req, "R8 limp entered", int'({limp, rst_req}), 2);
    sys_meas(hi, lo);
    chk(hi + lo == 32, "R8 limp period", hi + lo, 32);
    ref_sync(pp, 5);
    ref_run(pp, 20);
    chk(limp && !lock, "R8 limp held on misaligned", int'({limp, lock}), 2);
    repeat (pp - 5) @(negedge clk);
    ref_run(pp, 16);
    chk(!limp && lock, "R8 limp exit on lock", int'({limp, lock}), 1);

    // R7 reset request timing
    re_s = 1;
    wr_cfg();
    repeat (pp - 8) @(negedge clk);
    chk(!rst_req, "R7 before window", int'(rst_req), 0);
    repeat (12) @(negedge clk);
    chk(rst_req && !limp, "R7 request raised", int'({rst_req, limp}), 2);
    chk(!lock, "R6 loss clears lock", int'(lock), 0);
    ref_r = 1'b1;
    @(negedge clk);
    ref_r = 1'b0;
    repeat (5) @(negedge clk);
    chk(!rst_req, "R7 cleared by edge", int'(rst_req), 0);

    ext_r = 1'b1;
    repeat (300) @(negedge clk);
    chk(lock && !rst_req && !limp, "R9 ext parks monitor", int'({lock, rst_req, limp}), 4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule